// File: doc/BRIEF.md
# Serial Test Pattern Generator with Rate-Based Bit Inversion

This block is the sending half of a bit-error-rate tester. It emits one test bit per clock in which `bit_en` is high. The test stream is one of two kinds. In the first, a stored 32-bit word is repeated, most significant bit first. In the second, a pseudo-random sequence starts from the same 32-bit word used as a seed. Because the stream moves only on `bit_en`, a framer can leave gaps for overhead positions.

A decimal error injector inverts single output bits at a rate of one in 10^n, where n is a 3-bit field. The count covers enabled bits only. If the rate is changed while injection is running, the new rate takes over only after the next error at the old rate has been inserted. All settings arrive through a small register write port: two 16-bit halves of the seed/pattern word and one control word that holds the mode and the rate.

Top module: `tx_pattern_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `tx_bit`, `tx_stb` and `tx_err` are 0. The seed word, the mode and the rate also reset to 0.
- R2: A write to address 0 loads seed bits 15..0 and a write to address 1 loads seed bits 31..16. Any write to address 0, 1 or 2 reloads the generator from the seed. The first enabled bit after a reload is seed bit 31.
- R3: When control bit 0 is 0 (repeat mode), the output is the 32-bit seed word sent again and again: bit 31 first, then 30 down to 0, then bit 31 again.
- R4: The generator and the error count advance only on clocks with `bit_en` high. The next clock then shows `tx_stb` high with the new `tx_bit`. Otherwise `tx_stb` is 0 and `tx_bit` holds its value. `bit_en` is ignored in the clock that follows a register write.
- R5: When control bit 0 is 1 (PRBS mode, default length 15), the first 32 output bits are seed bits 31 down to 0. After that, every bit x[k] equals x[k-15] XOR x[k-14].
- R6: Control bits 5..3 hold the rate n. When a nonzero n is written while injection is idle, the count starts from zero. The 10^n-th enabled bit after that write is inverted, and so is every 10^n-th enabled bit after it. `tx_err` is high together with each inverted bit.
- R7: If a rate is written while injection is running, the next error still comes at the old spacing, counted from the previous error. The new spacing applies from that error on. A later write before the switch replaces the pending value.
- R8: A rate of 0 means no inversion. If 0 is written while injection is idle, no error is inserted. If 0 is written while injection is running, exactly one more error is inserted at the old spacing and none after it.
- R9: Control bits 15..6 and 2..1 have no effect. A write to address 3 changes nothing: the stream and the error spacing continue undisturbed.
- R10: A seed or mode reload in the middle of a run restarts the pattern. It does not reset the error spacing count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 seed low half, 1 seed high half, 2 control |
| wr_data | input | 16 | Register write data |
| bit_en | input | 1 | Advance the stream by one bit this clock |
| tx_bit | output | 1 | Registered output test bit |
| tx_stb | output | 1 | High for one clock when `tx_bit` carries a new bit |
| tx_err | output | 1 | High when the new bit was inverted |

## Verification
On every cycle, the checker confirms the following: a strobe only follows an enable, an error flag only comes with a strobe, the output bit holds between strobes, no error appears while the active rate is zero, and the spacing counter stays below 10^n. The bench's behavioural model shows what these per-cycle rules cannot. It checks that the bit sequences are correct in repeat mode and in PRBS mode, that the exact spacing of errors holds at several rates and with a gapped enable, that a rate change mid-run is deferred to the next error, and that reserved bits and an unused address are ignored.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int MODE_BIT  = 0;
  localparam int RATE_LSB  = 3;
  localparam int RATE_W    = 3;
  localparam int WORD_W    = 32;
  localparam int HALF_W    = 16;

  typedef enum logic {
    MODE_REPEAT = 1'b0,
    MODE_PRBS   = 1'b1
  } gen_mode_e;

  typedef enum logic [1:0] {
    ADDR_SEED_LO = 2'd0,
    ADDR_SEED_HI = 2'd1,
    ADDR_CTRL    = 2'd2
  } reg_addr_e;

  function automatic int unsigned pow10(input int unsigned n);
    int unsigned r;
    r = 1;
    for (int i = 0; i < 8; i++) begin
      if (i < n) r = r * 10;
    end
    return r;
  endfunction

  function automatic int prbs_tap(input int len);
    case (len)
      23:      return 18;
      31:      return 28;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/ptg_cfg_regs.sv
module ptg_cfg_regs
  import ptg_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [2*DW-1:0]   seed,
  output gen_mode_e         mode,
  output logic              ld,
  output logic              rate_wr,
  output logic [RATE_W-1:0] rate_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seed     <= '0;
      mode     <= MODE_REPEAT;
      ld       <= 1'b0;
      rate_wr  <= 1'b0;
      rate_val <= '0;
    end else begin
      ld      <= 1'b0;
      rate_wr <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          ADDR_SEED_LO: begin
            seed[DW-1:0] <= wr_data;
            ld           <= 1'b1;
          end
          ADDR_SEED_HI: begin
            seed[2*DW-1:DW] <= wr_data;
            ld              <= 1'b1;
          end
          ADDR_CTRL: begin
            mode     <= gen_mode_e'(wr_data[MODE_BIT]);
            rate_val <= wr_data[RATE_LSB +: RATE_W];
            ld       <= 1'b1;
            rate_wr  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ptg_seq_gen.sv
module ptg_seq_gen
  import ptg_pkg::*;
#(
  parameter int SW       = 32,
  parameter int PRBS_LEN = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [SW-1:0] seed,
  input  gen_mode_e     mode,
  input  logic          adv,
  output logic          cur_bit
);
  localparam int TAP = prbs_tap(PRBS_LEN);

  logic [SW-1:0] sh;
  logic          fb;

  generate
    if (PRBS_LEN == 23) begin : g_p23
      assign fb = sh[22] ^ sh[TAP-1];
    end else if (PRBS_LEN == 31) begin : g_p31
      assign fb = sh[30] ^ sh[TAP-1];
    end else begin : g_p15
      assign fb = sh[14] ^ sh[TAP-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else if (ld) begin
      sh <= seed;
    end else if (adv) begin
      if (mode == MODE_PRBS) sh <= {sh[SW-2:0], fb};
      else                   sh <= {sh[SW-2:0], sh[SW-1]};
    end
  end

  assign cur_bit = sh[SW-1];
endmodule

// File: rtl/ptg_err_ins.sv
module ptg_err_ins
  import ptg_pkg::*;
#(
  parameter int MAX_N = 7,
  parameter int CW    = $clog2(pow10(MAX_N) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_val,
  input  logic              adv,
  output logic              err_now,
  output logic [RATE_W-1:0] act_n,
  output logic [CW-1:0]     cnt
);
  logic [RATE_W-1:0] pend_n;
  logic              pend_v;
  logic [CW-1:0]     lim_m1;
  logic              hit;

  always_comb begin
    lim_m1 = '0;
    for (int i = 1; i <= MAX_N; i++) begin
      if (act_n == RATE_W'(i)) lim_m1 = CW'(pow10(i) - 1);
    end
  end

  assign hit     = (act_n != '0) && (cnt == lim_m1);
  assign err_now = adv && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_n  <= '0;
      pend_n <= '0;
      pend_v <= 1'b0;
      cnt    <= '0;
    end else if (rate_wr) begin
      if (act_n == '0) begin
        act_n  <= rate_val;
        cnt    <= '0;
        pend_v <= 1'b0;
      end else begin
        pend_n <= rate_val;
        pend_v <= 1'b1;
      end
    end else if (adv && act_n != '0) begin
      if (hit) begin
        cnt <= '0;
        if (pend_v) begin
          act_n  <= pend_n;
          pend_v <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_pattern_gen.sv
module tx_pattern_gen
  import ptg_pkg::*;
#(
  parameter int AW       = 2,
  parameter int DW       = HALF_W,
  parameter int PRBS_LEN = 15,
  parameter int MAX_N    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          bit_en,
  output logic          tx_bit,
  output logic          tx_stb,
  output logic          tx_err
);
  localparam int SW = 2 * DW;
  localparam int CW = $clog2(pow10(MAX_N) + 1);

  logic [SW-1:0]     seed;
  gen_mode_e         mode;
  logic              ld;
  logic              rate_wr;
  logic [RATE_W-1:0] rate_val;
  logic              adv;
  logic              gen_bit;
  logic              err_now;
  logic [RATE_W-1:0] act_n;
  logic [CW-1:0]     err_cnt;

  assign adv = bit_en & ~ld;

  ptg_cfg_regs #(.AW(AW), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .seed(seed), .mode(mode), .ld(ld), .rate_wr(rate_wr), .rate_val(rate_val)
  );

  ptg_seq_gen #(.SW(SW), .PRBS_LEN(PRBS_LEN)) u_gen (
    .clk(clk), .rst(rst), .ld(ld), .seed(seed), .mode(mode), .adv(adv),
    .cur_bit(gen_bit)
  );

  ptg_err_ins #(.MAX_N(MAX_N), .CW(CW)) u_err (
    .clk(clk), .rst(rst), .rate_wr(rate_wr), .rate_val(rate_val), .adv(adv),
    .err_now(err_now), .act_n(act_n), .cnt(err_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bit <= 1'b0;
      tx_stb <= 1'b0;
      tx_err <= 1'b0;
    end else begin
      tx_stb <= adv;
      tx_err <= err_now;
      if (adv) tx_bit <= gen_bit ^ err_now;
    end
  end
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker
  import ptg_pkg::*;
#(
  parameter int MAX_N = 7,
  parameter int CW    = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic              tx_bit,
  input logic              tx_stb,
  input logic              tx_err,
  input logic [RATE_W-1:0] act_n,
  input logic [CW-1:0]     err_cnt
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_stb && !tx_err));

  assert_stb_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
    tx_stb |-> $past(bit_en));

  assert_bit_holds_R4: assert property (@(posedge clk) disable iff (rst)
    !tx_stb |-> $stable(tx_bit));

  assert_err_with_stb_R6: assert property (@(posedge clk) disable iff (rst)
    tx_err |-> tx_stb);

  assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    (act_n != '0) |-> (64'(err_cnt) < 64'(pow10(int'(act_n)))));

  assert_off_no_err_R8: assert property (@(posedge clk) disable iff (rst)
    (act_n == '0) |=> !tx_err);
endmodule

bind tx_pattern_gen ptg_checker #(.MAX_N(MAX_N), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .tx_bit(tx_bit), .tx_stb(tx_stb),
  .tx_err(tx_err), .act_n(act_n), .err_cnt(err_cnt)
);

// File: tb/sim_tx_pattern_gen.sv
module sim_tx_pattern_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PL = 15;
  localparam int PT = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        bit_en = 1'b0;
  logic        tx_bit, tx_stb, tx_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_seed = '0;
  bit          m_prbs = 0;
  int          m_k = 0;
  bit          m_hist[$];
  int          m_act = 0;
  int          m_pend = 0;
  bit          m_pv = 0;
  int          m_cnt = 0;
  bit          m_last = 0;
  int          n_err_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_pattern_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bit_en(bit_en), .tx_bit(tx_bit), .tx_stb(tx_stb), .tx_err(tx_err)
  );

  function automatic int p10(int n);
    int r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; bit_en = 1'b0;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk); @(negedge clk);
    if (a != 2'd3) begin
      if (a == 2'd0) m_seed[15:0] = d;
      if (a == 2'd1) m_seed[31:16] = d;
      if (a == 2'd2) begin
        m_prbs = d[0];
        if (m_act == 0) begin
          m_act = int'(d[5:3]); m_cnt = 0; m_pv = 0;
        end else begin
          m_pend = int'(d[5:3]); m_pv = 1;
        end
      end
      m_k = 0;
      m_hist.delete();
    end
  endtask

  task automatic step(bit en, string req);
    bit b, e;
    bit_en = en;
    e = 0;
    if (en) begin
      if (!m_prbs)      b = m_seed[31 - (m_k % 32)];
      else if (m_k < 32) b = m_seed[31 - m_k];
      else              b = m_hist[m_k - PL] ^ m_hist[m_k - PT];
      m_hist.push_back(b);
      m_k++;
      if (m_act != 0) begin
        if (m_cnt == p10(m_act) - 1) begin
          e = 1; m_cnt = 0;
          if (m_pv) begin m_act = m_pend; m_pv = 0; end
        end else m_cnt++;
      end
      m_last = b ^ e;
    end
    @(posedge clk); @(negedge clk);
    bit_en = 1'b0;
    if (tx_err) n_err_seen++;
    check(tx_stb == en && tx_bit == m_last && tx_err == e, req,
          "stb/bit/err", {tx_stb, tx_bit, tx_err}, {en, m_last, e});
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) step(1'b1, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx_stb == 0 && tx_err == 0 && tx_bit == 0, "R1", "reset outputs",
          {tx_stb, tx_err, tx_bit}, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(tx_stb == 0 && tx_err == 0 && tx_bit == 0, "R1", "after reset",
          {tx_stb, tx_err, tx_bit}, 0);

    // R2 R3: repeat mode, seed halves
    reg_write(2'd0, 16'h1E79);
    reg_write(2'd1, 16'hA5C3);
    reg_write(2'd2, 16'h0000);
    run(80, "R3");

    // R4: gapped enable
    for (int i = 0; i < 60; i++) step(((i % 3) != 1), "R4");

    // R5: PRBS mode
    reg_write(2'd1, 16'h8000);
    reg_write(2'd0, 16'h0001);
    reg_write(2'd2, 16'h0001);
    run(150, "R5");

    // R6: rate n=1 in repeat mode
    reg_write(2'd2, 16'h0008);
    n_err_seen = 0;
    run(60, "R6");
    check(n_err_seen == 6, "R6", "errors in 60 bits n=1", n_err_seen, 6);

    // R7: running at n=1; change to n=2 mid-interval (reload restarts pattern)
    run(4, "R7");
    reg_write(2'd2, 16'h0010);
    run(230, "R7");
    // R8: change to 0 while running: one more error then none
    reg_write(2'd2, 16'h0000);
    n_err_seen = 0;
    run(300, "R8");
    check(n_err_seen == 1, "R8", "errors after rate 0 mid-run", n_err_seen, 1);

    // R8: rate 0 written while idle
    reg_write(2'd2, 16'h0001);
    n_err_seen = 0;
    run(120, "R8");
    check(n_err_seen == 0, "R8", "no errors when off", n_err_seen, 0);

    // R6: n=3 with gaps
    reg_write(2'd2, 16'h0019);
    n_err_seen = 0;
    for (int i = 0; i < 2600; i++) step((i % 5) != 0, "R6");
    check(n_err_seen == 2, "R6", "errors in 2080 enabled bits n=3", n_err_seen, 2);

    // R7: pending value replaced by later write
    reg_write(2'd2, 16'h0010);
    reg_write(2'd2, 16'h0008);
    run(1100, "R7");

    // R10: seed reload mid-run keeps spacing
    reg_write(2'd0, 16'hBEEF);
    run(60, "R10");

    // R9: reserved bits and address 3
    reg_write(2'd3, 16'hFFFF);
    run(40, "R9");
    reg_write(2'd2, 16'hFFC1);
    run(60, "R9");
    reg_write(2'd2, 16'h0000);
    run(40, "R9");

    // R2: upper half alone reloads, first bit is seed bit 31
    reg_write(2'd1, 16'h7FFF);
    run(34, "R2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule